// File: doc/BRIEF.md
# Flash Write-Status Read Path

This block sits between a host read port and the synchronous RAM that stands in for a parallel NOR flash array. While the array is busy with an internal byte program or erase, reads do not return stored data. They return a status byte instead. Bit 7 is a polarity-coded completion flag, bit 6 changes value on every read, and the low bits read as zero. When the block is idle, every read passes the array byte through unchanged.

The block owns the internal operation timers. Each one is a cycle counter whose length is a parameter, one for each operation kind. `op_start` is the pulse that the command decoder issues once the final write strobe of a command has been taken: the 4th strobe for a program, the 6th for an erase. From the next cycle the status encoding applies. After a program ends, a short settle window follows. In that window bit 7 already shows the true data, but the other bits are held at zero until the window expires. An erase has no settle window.

The array is a RAM with a registered read. The block forwards the read strobe and address to it in the same cycle. The result, either array data or status, appears on `rd_data` with `rd_valid` one cycle later.

Top module: `nor_wstat`

## Requirements
- R1: After reset, `busy` and `rd_valid` are 0.
- R2: `op_start` taken while `busy` is 0 sets `busy` from the next cycle. `busy` then stays high for exactly PGM_CYC, SECT_CYC or CHIP_CYC cycles for `op_kind` 2'b00 (byte program), 2'b01 (sector erase) or 2'b10 (chip erase).
- R3: A read sampled while a program is busy returns bit 7 as the complement of bit 7 of the `op_byte` captured at start.
- R4: A read sampled while an erase is busy returns bit 7 = 0.
- R5: Reads sampled while busy return bit 6 alternating from one read to the next. The first read after each accepted start returns 1, whatever the previous operation left behind.
- R6: Reads sampled while busy return bits 5..0 as zero.
- R7: For SETTLE_CYC cycles after a program ends, reads return bit 7 equal to array bit 7 and bits 6..0 as zero. From the next cycle on, reads return the full array byte.
- R8: When idle, a read returns the array byte at `rd_addr`, with `rd_valid` high in the cycle after `rd_en`. `mem_rd_en` and `mem_addr` follow `rd_en` and `rd_addr` in the same cycle.
- R9: `op_start` while `busy` is 1 is ignored. It neither restarts nor lengthens the running operation.
- R10: After an erase ends there is no settle window. The first read after `busy` falls returns the full array byte.
- R11: `op_start` with the reserved `op_kind` 2'b11 is ignored. `busy` stays 0 and reads keep returning array data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_start | input | 1 | Start pulse for an internal operation |
| op_kind | input | 2 | 00 program, 01 sector erase, 10 chip erase, 11 reserved |
| op_byte | input | 8 | Byte being programmed |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| mem_rd_en | output | 1 | Read enable to the array RAM |
| mem_addr | output | ADDR_W | Address to the array RAM |
| mem_rdata | input | 8 | Registered read data from the array RAM |
| rd_data | output | 8 | Read result, status or array data |
| rd_valid | output | 1 | Read result valid |
| busy | output | 1 | Internal operation in progress |

## Verification
The bound checker tests a set of properties in every cycle. These are the read latency, the zero low bits on busy reads, the zero bit 7 during an erase, the alternation of bit 6 and its first value of 1, the zeroed bits in the settle window, and the exact busy length for each kind, which also covers a start that arrives while busy. The absence of a settle window after an erase is checked the same way. The bench scenarios show what depends on array contents and on command order: the complement of the programmed bit, the exact cycle at which busy ends and full data returns, the reset of bit 6 at the next operation, and a reserved kind that leaves the block idle.

// File: rtl/nor_wstat_pkg.sv
`timescale 1ns/1ps
package nor_wstat_pkg;

  typedef enum logic [1:0] {
    OP_PGM  = 2'b00,
    OP_SECT = 2'b01,
    OP_CHIP = 2'b10,
    OP_RSVD = 2'b11
  } op_kind_e;

  typedef enum logic [1:0] {
    RM_ARRAY  = 2'b00,
    RM_STATUS = 2'b01,
    RM_SETTLE = 2'b10
  } rd_mode_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/nor_wstat_timer.sv
`timescale 1ns/1ps
module nor_wstat_timer
  import nor_wstat_pkg::*;
#(
  parameter int unsigned PGM_CYC    = 4000,
  parameter int unsigned SECT_CYC   = 5000000,
  parameter int unsigned CHIP_CYC   = 20000000,
  parameter int unsigned SETTLE_CYC = 200
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start_req,
  input  op_kind_e kind,
  input  logic     data_msb,
  output logic     accept,
  output logic     busy,
  output logic     is_pgm,
  output logic     poll_bit,
  output logic     settle
);

  localparam int unsigned MAX_CYC = max3(PGM_CYC, SECT_CYC, CHIP_CYC);
  localparam int unsigned CW      = $clog2(MAX_CYC + 1);
  localparam int unsigned SW      = $clog2(SETTLE_CYC + 1);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          pgm_q, pgm_d;
  logic          poll_q, poll_d;
  logic          settle_q, settle_d;
  logic [SW-1:0] scnt_q, scnt_d;
  logic [CW-1:0] load_val;

  always_comb begin
    case (kind)
      OP_PGM:  load_val = CW'(PGM_CYC - 1);
      OP_SECT: load_val = CW'(SECT_CYC - 1);
      default: load_val = CW'(CHIP_CYC - 1);
    endcase
  end

  assign accept = start_req && !busy_q && (kind != OP_RSVD);

  always_comb begin
    busy_d   = busy_q;
    cnt_d    = cnt_q;
    pgm_d    = pgm_q;
    poll_d   = poll_q;
    settle_d = settle_q;
    scnt_d   = scnt_q;
    if (accept) begin
      busy_d   = 1'b1;
      cnt_d    = load_val;
      pgm_d    = (kind == OP_PGM);
      poll_d   = ~data_msb;
      settle_d = 1'b0;
      scnt_d   = '0;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_d = 1'b0;
        if (pgm_q) begin
          settle_d = 1'b1;
          scnt_d   = SW'(SETTLE_CYC - 1);
        end
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end else if (settle_q) begin
      if (scnt_q == '0) begin
        settle_d = 1'b0;
      end else begin
        scnt_d = scnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      cnt_q    <= '0;
      pgm_q    <= 1'b0;
      poll_q   <= 1'b0;
      settle_q <= 1'b0;
      scnt_q   <= '0;
    end else begin
      busy_q   <= busy_d;
      cnt_q    <= cnt_d;
      pgm_q    <= pgm_d;
      poll_q   <= poll_d;
      settle_q <= settle_d;
      scnt_q   <= scnt_d;
    end
  end

  assign busy     = busy_q;
  assign is_pgm   = pgm_q;
  assign poll_bit = poll_q;
  assign settle   = settle_q;

endmodule

// File: rtl/nor_wstat_toggle.sv
`timescale 1ns/1ps
module nor_wstat_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic busy,
  input  logic rd_en,
  output logic tgl
);

  logic tgl_q, tgl_d;
  logic tgl_en;

  assign tgl_en = accept || (busy && rd_en);

  always_comb begin
    tgl_d = tgl_q;
    if (accept) begin
      tgl_d = 1'b1;
    end else if (busy && rd_en) begin
      tgl_d = ~tgl_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgl_q <= 1'b1;
    end else if (tgl_en) begin
      tgl_q <= tgl_d;
    end
  end

  assign tgl = tgl_q;

endmodule

// File: rtl/nor_wstat_rdpath.sv
`timescale 1ns/1ps
module nor_wstat_rdpath
  import nor_wstat_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          busy,
  input  logic          is_pgm,
  input  logic          poll_bit,
  input  logic          tgl,
  input  logic          settle,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);

  localparam int unsigned LOW_W = DW - 2;

  rd_mode_e mode_q, mode_d;
  logic     st7_q, st7_d;
  logic     st6_q, st6_d;
  logic     vld_q;

  always_comb begin
    if (busy) begin
      mode_d = RM_STATUS;
    end else if (settle) begin
      mode_d = RM_SETTLE;
    end else begin
      mode_d = RM_ARRAY;
    end
    st7_d = is_pgm ? poll_bit : 1'b0;
    st6_d = tgl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= RM_ARRAY;
      st7_q  <= 1'b0;
      st6_q  <= 1'b0;
    end else if (rd_en) begin
      mode_q <= mode_d;
      st7_q  <= st7_d;
      st6_q  <= st6_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= rd_en;
    end
  end

  always_comb begin
    case (mode_q)
      RM_STATUS: rd_data = {st7_q, st6_q, {LOW_W{1'b0}}};
      RM_SETTLE: rd_data = {mem_rdata[DW-1], {(DW-1){1'b0}}};
      default:   rd_data = mem_rdata;
    endcase
  end

  assign rd_valid = vld_q;

endmodule

// File: rtl/nor_wstat.sv
`timescale 1ns/1ps
module nor_wstat
  import nor_wstat_pkg::*;
#(
  parameter int unsigned ADDR_W     = 17,
  parameter int unsigned PGM_CYC    = 4000,
  parameter int unsigned SECT_CYC   = 5000000,
  parameter int unsigned CHIP_CYC   = 20000000,
  parameter int unsigned SETTLE_CYC = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_start,
  input  logic [1:0]        op_kind,
  input  logic [7:0]        op_byte,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  output logic              busy
);

  logic accept_w;
  logic busy_w;
  logic is_pgm_w;
  logic poll_w;
  logic settle_w;
  logic tgl_w;

  nor_wstat_timer #(
    .PGM_CYC   (PGM_CYC),
    .SECT_CYC  (SECT_CYC),
    .CHIP_CYC  (CHIP_CYC),
    .SETTLE_CYC(SETTLE_CYC)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_req(op_start),
    .kind     (op_kind_e'(op_kind)),
    .data_msb (op_byte[7]),
    .accept   (accept_w),
    .busy     (busy_w),
    .is_pgm   (is_pgm_w),
    .poll_bit (poll_w),
    .settle   (settle_w)
  );

  nor_wstat_toggle u_toggle (
    .clk   (clk),
    .rst_n (rst_n),
    .accept(accept_w),
    .busy  (busy_w),
    .rd_en (rd_en),
    .tgl   (tgl_w)
  );

  nor_wstat_rdpath #(
    .DW(8)
  ) u_rdpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .busy     (busy_w),
    .is_pgm   (is_pgm_w),
    .poll_bit (poll_w),
    .tgl      (tgl_w),
    .settle   (settle_w),
    .mem_rdata(mem_rdata),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

  assign mem_rd_en = rd_en;
  assign mem_addr  = rd_addr;
  assign busy      = busy_w;

endmodule

// File: rtl/nor_wstat_chk.sv
`timescale 1ns/1ps
module nor_wstat_chk #(
  parameter int unsigned PGM_CYC    = 4000,
  parameter int unsigned SECT_CYC   = 5000000,
  parameter int unsigned CHIP_CYC   = 20000000,
  parameter int unsigned SETTLE_CYC = 200
) (
  input logic       clk,
  input logic       rst_n,
  input logic       op_start,
  input logic [1:0] op_kind,
  input logic       rd_en,
  input logic       busy,
  input logic       rd_valid,
  input logic [7:0] rd_data,
  input logic       is_pgm,
  input logic       settle
);

  logic        taken;
  logic        stat_q;
  logic        prev_ok;
  logic        prev_dq6;
  int unsigned run_len;
  int unsigned exp_len;

  assign taken = op_start && !busy && (op_kind != 2'b11);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q   <= 1'b0;
      prev_ok  <= 1'b0;
      prev_dq6 <= 1'b0;
      run_len  <= 0;
      exp_len  <= 0;
    end else begin
      stat_q <= busy && rd_en;
      if (taken) begin
        prev_ok <= 1'b0;
        run_len <= 0;
        case (op_kind)
          2'b00:   exp_len <= PGM_CYC;
          2'b01:   exp_len <= SECT_CYC;
          default: exp_len <= CHIP_CYC;
        endcase
      end else begin
        if (busy) begin
          run_len <= run_len + 1;
        end
        if (rd_valid && stat_q) begin
          prev_ok  <= 1'b1;
          prev_dq6 <= rd_data[6];
        end
      end
    end
  end

  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    taken |=> busy);

  p_busy_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == exp_len));

  p_rsvd_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && !busy && op_kind == 2'b11) |=> !busy);

  p_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  p_novalid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

  p_low_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_en) |=> (rd_data[5:0] == 6'd0));

  p_erase_dq7_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !is_pgm && rd_en) |=> !rd_data[7]);

  p_tgl_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && stat_q && !prev_ok) |-> rd_data[6]);

  p_tgl_alt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && stat_q && prev_ok) |-> (rd_data[6] != prev_dq6));

  p_settle_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (settle && !busy && rd_en) |=> (rd_data[6:0] == 7'd0));

  p_no_settle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !is_pgm) |-> !settle);

endmodule

bind nor_wstat nor_wstat_chk #(
  .PGM_CYC   (PGM_CYC),
  .SECT_CYC  (SECT_CYC),
  .CHIP_CYC  (CHIP_CYC),
  .SETTLE_CYC(SETTLE_CYC)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .op_start(op_start),
  .op_kind (op_kind),
  .rd_en   (rd_en),
  .busy    (busy),
  .rd_valid(rd_valid),
  .rd_data (rd_data),
  .is_pgm  (is_pgm_w),
  .settle  (settle_w)
);

// File: tb/test_nor_wstat.sv
`timescale 1ns/1ps
module test_nor_wstat;

  localparam int AW   = 8;
  localparam int PGM  = 12;
  localparam int SECT = 20;
  localparam int CHIP = 30;
  localparam int STL  = 5;

  // {kind[26:25], op_byte[24:17], addr[16:9], array byte[8:1], busy bit7[0]}
  localparam logic [26:0] VEC [0:5] = '{
    {2'b00, 8'h3C, 8'd10, 8'h3C, 1'b1},
    {2'b00, 8'hA5, 8'd20, 8'hA5, 1'b0},
    {2'b01, 8'h00, 8'd30, 8'hFF, 1'b0},
    {2'b10, 8'h00, 8'd40, 8'hFF, 1'b0},
    {2'b00, 8'h80, 8'd50, 8'h80, 1'b0},
    {2'b00, 8'h7F, 8'd60, 8'h7F, 1'b1}
  };

  logic          clk;
  logic          rst_n;
  logic          op_start;
  logic [1:0]    op_kind;
  logic [7:0]    op_byte;
  logic          rd_en;
  logic [AW-1:0] rd_addr;
  logic          mem_rd_en;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_rdata;
  logic [7:0]    rd_data;
  logic          rd_valid;
  logic          busy;

  logic [7:0] mem [0:255];
  int checks;
  int fails;
  bit done;

  nor_wstat #(
    .ADDR_W(AW), .PGM_CYC(PGM), .SECT_CYC(SECT), .CHIP_CYC(CHIP), .SETTLE_CYC(STL)
  ) i_nor_wstat (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_kind(op_kind),
    .op_byte(op_byte), .rd_en(rd_en), .rd_addr(rd_addr), .mem_rd_en(mem_rd_en),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .rd_data(rd_data),
    .rd_valid(rd_valid), .busy(busy)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= mem[mem_addr];
  end

  task automatic chk(input bit ok, input string tag, input logic [7:0] act,
                     input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic do_read(input logic [AW-1:0] a, output logic [7:0] d);
    rd_en   = 1'b1;
    rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d     = rd_data;
    chk(rd_valid === 1'b1, "R8 rd_valid", {7'd0, rd_valid}, 8'h01);
  endtask

  task automatic start_op(input logic [1:0] k, input logic [7:0] b);
    op_start = 1'b1;
    op_kind  = k;
    op_byte  = b;
    @(negedge clk);
    op_start = 1'b0;
  endtask

  function automatic int dur(input logic [1:0] k);
    return (k == 2'b00) ? PGM : (k == 2'b01) ? SECT : CHIP;
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    checks = 0; fails = 0; done = 0;
    rst_n = 1'b0; op_start = 1'b0; op_kind = 2'b00; op_byte = 8'h00;
    rd_en = 1'b0; rd_addr = '0;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy", {7'd0, busy}, 8'h00);
    chk(rd_valid == 1'b0, "R1 rd_valid", {7'd0, rd_valid}, 8'h00);

    // R8: idle pass-through and same-cycle forwarding
    mem[5] = 8'h5A;
    rd_en = 1'b1; rd_addr = 8'd5;
    #1;
    chk(mem_rd_en == 1'b1 && mem_addr == 8'd5, "R8 forward", mem_addr, 8'd5);
    @(negedge clk);
    rd_en = 1'b0;
    chk(rd_data == 8'h5A, "R8 idle read", rd_data, 8'h5A);

    // vector table
    for (int i = 0; i < 6; i++) begin
      logic [1:0] k;
      logic [7:0] ob, a, mv;
      logic e7;
      int dd;
      {k, ob, a, mv, e7} = VEC[i];
      mem[a] = mv;
      dd = dur(k);
      start_op(k, ob);
      chk(busy == 1'b1, "R2 busy set", {7'd0, busy}, 8'h01);
      for (int r = 1; r <= 3; r++) begin
        do_read(a, d);
        chk(d[7] == e7, (k == 2'b00) ? "R3 poll bit" : "R4 erase bit", d, {e7, 7'd0});
        chk(d[6] == r[0], "R5 toggle", d, {1'b0, r[0], 6'd0});
        chk(d[5:0] == 6'd0, "R6 low bits", d, 8'h00);
      end
      start_op(2'b10, 8'h00);  // R9: must be ignored
      repeat (dd - 5) @(negedge clk);
      do_read(a, d);
      chk(d == {e7, 7'b0}, "R9 last busy read", d, {e7, 7'd0});
      chk(busy == 1'b0, "R2 busy length", {7'd0, busy}, 8'h00);
      if (k == 2'b00) begin
        do_read(a, d);
        chk(d == {mv[7], 7'b0}, "R7 settle first", d, {mv[7], 7'd0});
        repeat (STL - 2) @(negedge clk);
        do_read(a, d);
        chk(d == {mv[7], 7'b0}, "R7 settle last", d, {mv[7], 7'd0});
        do_read(a, d);
        chk(d == mv, "R7 full data", d, mv);
      end else begin
        do_read(a, d);
        chk(d == mv, "R10 erase no settle", d, mv);
      end
    end

    // R5: toggle restarts at 1 on next operation
    mem[70] = 8'h11;
    start_op(2'b00, 8'h11);
    do_read(8'd70, d);
    chk(d[6] == 1'b1, "R5 first read", d, 8'hC0);
    repeat (PGM + STL + 2) @(negedge clk);
    start_op(2'b01, 8'h00);
    do_read(8'd70, d);
    chk(d[6] == 1'b1, "R5 restart", d, 8'h40);
    repeat (SECT + 2) @(negedge clk);
    chk(busy == 1'b0, "R2 erase done", {7'd0, busy}, 8'h00);

    // R11: reserved kind ignored
    mem[80] = 8'h3E;
    start_op(2'b11, 8'h00);
    chk(busy == 1'b0, "R11 no busy", {7'd0, busy}, 8'h00);
    do_read(8'd80, d);
    chk(d == 8'h3E, "R11 array data", d, 8'h3E);

    done = 1;
    summary();
    $finish;
  end

endmodule